// File: doc/BRIEF.md
# Serial Command/Data Receiver with Identity Readback

This block is the slave end of a synchronous serial link gated by an active-low chip select. A host sends a transfer as a control byte followed by payload bytes, most significant bit first, sampled on the rising edge of the serial clock. The control byte says whether the payload goes to the command path or to display memory. It also says whether a further control byte follows the next payload byte or all remaining bytes form one stream, and whether the host wants to read. The block turns each completed payload byte into a one-cycle strobe with its value, on either the command outputs or the data outputs.

On a read request the block shifts out a byte on the serial data output, changing it on falling clock edges. The byte is either an identity code built from a fixed six-bit prefix and a two-bit board strap, or a status byte supplied by the surrounding logic, selected by a register bit held elsewhere. The serial output is only driven during such a read; otherwise the output-enable is low. All serial inputs are synchronised into the system clock domain, and raising chip select returns the receiver to its idle state at any point. Executing the commands is left to downstream logic.

Top module: `serial_cmd_rx`

## Requirements
- R1: While chip select is high the receiver is held idle: no strobes occur, the output-enable is low, and bits of an unfinished byte are discarded, so the next transfer starts afresh with a control byte.
- R2: Bits are taken MSB first on rising serial clock edges; the first byte after chip select falls is a control byte with continuation at bit 7, data/command at bit 6, read at bit 5, page at bits 4:3 and extension at bit 2 (bits 1:0 are ignored).
- R3: After a write control byte with bit 6 = 0, the next byte raises cmdStb once with that byte on cmdByte.
- R4: After a write control byte with bit 6 = 1, the next byte raises dataStb once with that byte on dataByte.
- R5: With bit 7 = 1, exactly one payload byte follows and the byte after it is decoded as a new control byte.
- R6: With bit 7 = 0, every following byte until chip select rises is payload of the same kind, even if its value looks like a control byte.
- R7: cmdPage and cmdExt show the page and extension fields of the most recent control byte whenever cmdStb is high.
- R8: With bit 5 = 1, the block drives the read byte MSB first from the first falling edge after the control byte, changing on each falling edge and repeating every eight bits, and raises no strobe until chip select rises.
- R9: The read byte is 001111 followed by strap[1:0] when readStatus is 0, and statusByte when readStatus is 1, as sampled when the control byte completes.
- R10: sdoutOe is low after reset and throughout write transfers, and high only during a read.
- R11: Each strobe lasts one system clock cycle and cmdStb and dataStb are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdin | input | 1 | Serial data from the host |
| strap | input | 2 | Board strap forming the low identity bits |
| readStatus | input | 1 | Selects status byte (1) or identity (0) for reads |
| statusByte | input | 8 | Status value returned when readStatus is 1 |
| cmdStb | output | 1 | One-cycle pulse for a received command byte |
| cmdByte | output | 8 | Value of the command byte |
| dataStb | output | 1 | One-cycle pulse for a received display-data byte |
| dataByte | output | 8 | Value of the display-data byte |
| cmdPage | output | 2 | Page field of the latest control byte |
| cmdExt | output | 1 | Extension field of the latest control byte |
| sdout | output | 1 | Serial read data |
| sdoutOe | output | 1 | Drive enable for sdout; low means high impedance |

## Verification
Directed transfers cover a chained command word, a command stream whose bytes carry the continuation bit set, and a transfer cut off mid-byte. These separate correct continuation handling from a decoder that re-reads control bytes in stream mode or keeps stale bits. Reads are tried with each source and different straps, over sixteen clocks, so a wrong bit order, a missing repeat or a wrong source shows up. Seeded random transfers mix chain lengths, stream lengths, payload kinds and page fields, and compare every strobe against a bench-built expectation list.

// File: rtl/serrx_pkg.sv
package serrx_pkg;
  localparam int CONT_POS = 7;
  localparam int KIND_POS = 6;
  localparam int READ_POS = 5;
  localparam int PAGE_HI = 4;
  localparam int EXT_POS = 2;

  typedef enum logic [1:0] {
    ST_CTRL   = 2'd0,
    ST_WORD   = 2'd1,
    ST_STREAM = 2'd2,
    ST_READ   = 2'd3
  } rxState_e;

  typedef struct packed {
    logic clear;
    logic shift;
    logic takeCtrl;
    logic emit;
    logic loadRead;
    logic rotRead;
  } dpCtl_t;
endpackage

// File: rtl/serrx_ctrl.sv
module serrx_ctrl
  import serrx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   csActive,
  input  logic   sclkRise,
  input  logic   sclkFall,
  input  logic   nowCont,
  input  logic   nowRead,
  output dpCtl_t ctl
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  rxState_e state, nextState;
  logic [CNT_W-1:0] bitCnt;
  logic contQ;
  logic byteEnd;

  assign byteEnd = sclkRise && (state != ST_READ) && (bitCnt == LAST_BIT);

  always_comb begin
    ctl = '0;
    nextState = state;
    if (!csActive) begin
      ctl.clear = 1'b1;
      nextState = ST_CTRL;
    end else begin
      if (sclkRise && state != ST_READ) ctl.shift = 1'b1;
      if (byteEnd) begin
        case (state)
          ST_CTRL: begin
            if (nowRead) begin
              ctl.loadRead = 1'b1;
              nextState = ST_READ;
            end else begin
              ctl.takeCtrl = 1'b1;
              nextState = ST_WORD;
            end
          end
          ST_WORD: begin
            ctl.emit = 1'b1;
            nextState = contQ ? ST_CTRL : ST_STREAM;
          end
          ST_STREAM: ctl.emit = 1'b1;
          default: ;
        endcase
      end
      if (sclkFall && state == ST_READ) ctl.rotRead = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_CTRL;
      bitCnt <= '0;
      contQ <= 1'b0;
    end else if (!csActive) begin
      state <= ST_CTRL;
      bitCnt <= '0;
      contQ <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.shift) bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
      if (ctl.takeCtrl) contQ <= nowCont;
    end
  end
endmodule

// File: rtl/serrx_dp.sv
module serrx_dp
  import serrx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int STRAP_W = 2,
  parameter logic [BYTE_W-STRAP_W-1:0] ID_PREFIX = 6'b001111
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic               sdinBit,
  input  logic [STRAP_W-1:0] strap,
  input  logic               readStatus,
  input  logic [BYTE_W-1:0]  statusByte,
  output logic               nowCont,
  output logic               nowRead,
  output logic               cmdStb,
  output logic [BYTE_W-1:0]  cmdByte,
  output logic               dataStb,
  output logic [BYTE_W-1:0]  dataByte,
  output logic [1:0]         cmdPage,
  output logic               cmdExt,
  output logic               sdoutBit,
  output logic               driveEn
);
  logic [BYTE_W-1:0] shReg;
  logic [BYTE_W-1:0] byteNow;
  logic [BYTE_W-1:0] rdSh;
  logic [BYTE_W-1:0] idByte;
  logic [1:0] unusedSpare;
  logic kindQ;

  assign byteNow = {shReg[BYTE_W-2:0], sdinBit};
  assign nowCont = byteNow[CONT_POS];
  assign nowRead = byteNow[READ_POS];
  assign unusedSpare = byteNow[1:0];
  assign idByte = {ID_PREFIX, strap};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      rdSh <= '0;
      kindQ <= 1'b0;
      cmdStb <= 1'b0;
      cmdByte <= '0;
      dataStb <= 1'b0;
      dataByte <= '0;
      cmdPage <= '0;
      cmdExt <= 1'b0;
      sdoutBit <= 1'b0;
      driveEn <= 1'b0;
    end else begin
      cmdStb <= 1'b0;
      dataStb <= 1'b0;
      if (ctl.clear) begin
        shReg <= '0;
        driveEn <= 1'b0;
        sdoutBit <= 1'b0;
      end else begin
        if (ctl.shift) shReg <= byteNow;
        if (ctl.takeCtrl) begin
          kindQ <= byteNow[KIND_POS];
          cmdPage <= byteNow[PAGE_HI -: 2];
          cmdExt <= byteNow[EXT_POS];
        end
        if (ctl.emit) begin
          if (kindQ) begin
            dataStb <= 1'b1;
            dataByte <= byteNow;
          end else begin
            cmdStb <= 1'b1;
            cmdByte <= byteNow;
          end
        end
        if (ctl.loadRead) rdSh <= readStatus ? statusByte : idByte;
        if (ctl.rotRead) begin
          sdoutBit <= rdSh[BYTE_W-1];
          rdSh <= {rdSh[BYTE_W-2:0], rdSh[BYTE_W-1]};
          driveEn <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import serrx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int STRAP_W = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-STRAP_W-1:0] ID_PREFIX = 6'b001111
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               sclk,
  input  logic               sdin,
  input  logic [STRAP_W-1:0] strap,
  input  logic               readStatus,
  input  logic [BYTE_W-1:0]  statusByte,
  output logic               cmdStb,
  output logic [BYTE_W-1:0]  cmdByte,
  output logic               dataStb,
  output logic [BYTE_W-1:0]  dataByte,
  output logic [1:0]         cmdPage,
  output logic               cmdExt,
  output logic               sdout,
  output logic               sdoutOe
);
  logic [SYNC_STAGES-1:0] csSync, sclkSync, sdinSync;
  logic sclkPrev;
  logic csActive, sclkS, sclkRise, sclkFall;
  logic nowCont, nowRead;
  dpCtl_t ctl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync <= '1;
      sclkSync <= '0;
      sdinSync <= '0;
      sclkPrev <= 1'b0;
    end else begin
      csSync <= {csSync[SYNC_STAGES-2:0], csN};
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
      sdinSync <= {sdinSync[SYNC_STAGES-2:0], sdin};
      sclkPrev <= sclkS;
    end
  end

  assign csActive = !csSync[SYNC_STAGES-1];
  assign sclkS = sclkSync[SYNC_STAGES-1];
  assign sclkRise = sclkS && !sclkPrev;
  assign sclkFall = !sclkS && sclkPrev;

  serrx_ctrl #(.BYTE_W(BYTE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .csActive(csActive),
    .sclkRise(sclkRise), .sclkFall(sclkFall),
    .nowCont(nowCont), .nowRead(nowRead), .ctl(ctl)
  );

  serrx_dp #(.BYTE_W(BYTE_W), .STRAP_W(STRAP_W), .ID_PREFIX(ID_PREFIX)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdinBit(sdinSync[SYNC_STAGES-1]),
    .strap(strap), .readStatus(readStatus), .statusByte(statusByte),
    .nowCont(nowCont), .nowRead(nowRead),
    .cmdStb(cmdStb), .cmdByte(cmdByte), .dataStb(dataStb), .dataByte(dataByte),
    .cmdPage(cmdPage), .cmdExt(cmdExt), .sdoutBit(sdout), .driveEn(sdoutOe)
  );
endmodule

// File: rtl/serrx_chk.sv
module serrx_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic cmdStb,
  input logic dataStb,
  input logic sdoutOe
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdStb && dataStb));

  // R11
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStb |=> !cmdStb);

  // R11
  data_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataStb |=> !dataStb);

  // R1
  cs_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && csN && $past(csN) && $past(csN, 2) && $past(csN, 3))
      |-> (!cmdStb && !dataStb && !sdoutOe));

  // R8
  read_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdoutOe |-> (!cmdStb && !dataStb));
endmodule

bind serial_cmd_rx serrx_chk i_chk (
  .clk(clk), .rstN(rstN), .csN(csN),
  .cmdStb(cmdStb), .dataStb(dataStb), .sdoutOe(sdoutOe)
);

// File: tb/test_serial_cmd_rx.sv
module test_serial_cmd_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic [1:0] strap = 2'b00;
  logic readStatus = 1'b0;
  logic [7:0] statusByte = 8'h00;
  logic cmdStb, dataStb, cmdExt, sdout, sdoutOe;
  logic [7:0] cmdByte, dataByte;
  logic [1:0] cmdPage;

  int nChk = 0, nFail = 0;
  int nCmd = 0, nData = 0, nExpCmd = 0, nExpData = 0;
  int pulseErr = 0;
  logic prevCmd = 1'b0, prevData = 1'b0;
  logic [7:0] cmdLog [256];
  logic [2:0] attrLog [256];
  logic [7:0] dataLog [256];
  logic [7:0] expCmd [256];
  logic [2:0] expAttr [256];
  logic [7:0] expData [256];
  logic [2:0] curAttr;

  always #4 clk = ~clk;

  serial_cmd_rx i_serial_cmd_rx (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdin(sdin),
    .strap(strap), .readStatus(readStatus), .statusByte(statusByte),
    .cmdStb(cmdStb), .cmdByte(cmdByte), .dataStb(dataStb), .dataByte(dataByte),
    .cmdPage(cmdPage), .cmdExt(cmdExt), .sdout(sdout), .sdoutOe(sdoutOe)
  );

  always @(posedge clk) begin
    if (rstN) begin
      prevCmd <= cmdStb;
      prevData <= dataStb;
      if ((cmdStb && prevCmd) || (dataStb && prevData) || (cmdStb && dataStb))
        pulseErr <= pulseErr + 1;
      if (cmdStb) begin
        cmdLog[nCmd[7:0]] <= cmdByte;
        attrLog[nCmd[7:0]] <= {cmdPage, cmdExt};
        nCmd <= nCmd + 1;
      end
      if (dataStb) begin
        dataLog[nData[7:0]] <= dataByte;
        nData <= nData + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  task automatic xfer(input logic [7:0] b, input int nb, output logic [7:0] got);
    got = 8'h00;
    for (int i = 7; i >= 8 - nb; i--) begin
      sclk = 1'b0;
      sdin = b[i];
      repeat (4) @(negedge clk);
      got[i] = sdout;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    logic [7:0] dummy;
    xfer(b, 8, dummy);
  endtask

  task automatic csLow();
    @(negedge clk);
    csN = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic csHigh();
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // control byte: bit7 cont, bit6 kind, bit5 read, bits4:3 page, bit2 ext
  function automatic logic [7:0] mkCtrl(input logic cont, input logic kind,
                                        input logic rd, input logic [1:0] pg, input logic ex);
    return {cont, kind, rd, pg, ex, 2'b00};
  endfunction

  task automatic expPayload(input logic kind, input logic [7:0] b);
    if (kind) begin
      expData[nExpData[7:0]] = b;
      nExpData++;
    end else begin
      expCmd[nExpCmd[7:0]] = b;
      expAttr[nExpCmd[7:0]] = curAttr;
      nExpCmd++;
    end
  endtask

  task automatic sendCtrl(input logic cont, input logic kind, input logic [1:0] pg, input logic ex);
    sendByte(mkCtrl(cont, kind, 1'b0, pg, ex));
    curAttr = {pg, ex};
  endtask

  function automatic logic [7:0] expectRead(input logic rs, input logic [7:0] st, input logic [1:0] sp);
    return rs ? st : {6'b001111, sp};
  endfunction

  task automatic doRead(input logic rs, input logic [7:0] st, input logic [1:0] sp);
    logic [7:0] g0, g1;
    int c0, d0;
    readStatus = rs;
    statusByte = st;
    strap = sp;
    c0 = nCmd;
    d0 = nData;
    csLow();
    sendByte(mkCtrl(1'b0, 1'b0, 1'b1, 2'b00, 1'b0));
    xfer(8'h00, 8, g0);
    xfer(8'hFF, 8, g1);
    chk("R9 first read byte", {24'd0, g0}, {24'd0, expectRead(rs, st, sp)});
    chk("R8 repeated read byte", {24'd0, g1}, {24'd0, expectRead(rs, st, sp)});
    chk("R10 oe high while reading", {31'd0, sdoutOe}, 32'd1);
    csHigh();
    chk("R8 no strobes in read", (nCmd - c0) + (nData - d0), 32'd0);
    chk("R1 oe low after cs high", {31'd0, sdoutOe}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] junk;
    void'($urandom(32'd20240611));
    curAttr = 3'b000;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    // reset state: R10, R1
    chk("R10 oe after reset", {31'd0, sdoutOe}, 32'd0);
    chk("R1 no strobes after reset", nCmd + nData, 32'd0);

    // R2 R3 R5 R7: chained command word then R4 R6 data stream
    csLow();
    sendCtrl(1'b1, 1'b0, 2'b10, 1'b1);
    sendByte(8'h3C); expPayload(1'b0, 8'h3C);
    chk("R10 oe low during write", {31'd0, sdoutOe}, 32'd0);
    sendCtrl(1'b0, 1'b1, 2'b01, 1'b0);
    for (int i = 0; i < 3; i++) begin
      sendByte(8'hA0 + 8'(i)); expPayload(1'b1, 8'hA0 + 8'(i));
    end
    csHigh();
    chk("R3 one command", nCmd, 32'd1);
    chk("R3 command value", {24'd0, cmdLog[0]}, 32'h3C);
    chk("R7 page/ext at command", {29'd0, attrLog[0]}, 32'b101);
    chk("R4 data count", nData, 32'd3);
    chk("R6 last stream byte", {24'd0, dataLog[2]}, 32'hA2);

    // R6: command stream whose bytes look like control bytes
    csLow();
    sendCtrl(1'b0, 1'b0, 2'b01, 1'b0);
    sendByte(8'hFF); expPayload(1'b0, 8'hFF);
    sendByte(8'hE0); expPayload(1'b0, 8'hE0);
    sendByte(8'h40); expPayload(1'b0, 8'h40);
    csHigh();
    chk("R6 stream commands", nCmd, 32'd4);
    chk("R6 no data from stream", nData, 32'd3);

    // R1: aborted partial byte discarded
    csLow();
    sendCtrl(1'b0, 1'b1, 2'b00, 1'b0);
    xfer(8'hF0, 4, junk);
    csHigh();
    csLow();
    sendCtrl(1'b1, 1'b0, 2'b11, 1'b0);
    sendByte(8'h55); expPayload(1'b0, 8'h55);
    csHigh();
    chk("R1 partial byte discarded", nData, 32'd3);
    chk("R1 fresh control after abort", {24'd0, cmdLog[4]}, 32'h55);

    // R8 R9 reads
    doRead(1'b0, 8'h00, 2'b10);
    doRead(1'b1, 8'hA5, 2'b01);
    doRead(1'b0, 8'h99, 2'b01);

    // random transfers
    for (int it = 0; it < 20; it++) begin
      int nWords, nStream;
      logic kind;
      if (($urandom() % 5) == 0) begin
        doRead(1'($urandom()), 8'($urandom()), 2'($urandom()));
        continue;
      end
      nWords = $urandom() % 3;
      nStream = $urandom() % 4;
      csLow();
      for (int w = 0; w < nWords; w++) begin
        logic [7:0] b;
        kind = 1'($urandom());
        sendCtrl(1'b1, kind, 2'($urandom()), 1'($urandom()));
        b = 8'($urandom());
        sendByte(b); expPayload(kind, b);
      end
      kind = 1'($urandom());
      sendCtrl(1'b0, kind, 2'($urandom()), 1'($urandom()));
      for (int s = 0; s < nStream; s++) begin
        logic [7:0] b;
        b = 8'($urandom());
        sendByte(b); expPayload(kind, b);
      end
      csHigh();
    end

    // final comparison against bench-built lists: R3 R4 R5 R6 R7
    chk("R3 total command count", nCmd, nExpCmd);
    chk("R4 total data count", nData, nExpData);
    for (int i = 0; i < nExpCmd && i < nCmd; i++) begin
      chk("R5 command byte", {24'd0, cmdLog[i]}, {24'd0, expCmd[i]});
      chk("R7 command attributes", {29'd0, attrLog[i]}, {29'd0, expAttr[i]});
    end
    for (int i = 0; i < nExpData && i < nData; i++)
      chk("R6 data byte", {24'd0, dataLog[i]}, {24'd0, expData[i]});
    chk("R11 strobe pulse shape", pulseErr, 32'd0);
    finishRun();
  end
endmodule